// File: doc/BRIEF.md
# Single-Carrier Multilevel Arm Modulator

This block produces the switching pattern for one arm of a series stack of identical submodules. A single reference and a single triangular carrier drive it. The reference is an unsigned fixed-point number whose unit is one average capacitor voltage. The block splits that number into two parts:

- a whole part, which is the count of modules that stay fully inserted for a carrier period;
- a fraction, which sets the duty of the one module that switches.

An up/down counter forms a symmetric triangle. Its half-period is chosen at run time. The fraction is compared against this triangle to give a single PWM bit, so one comparator serves the whole arm instead of one carrier per level.

The whole part and the fraction are captured once per carrier period, at the valley of the triangle. They then stay fixed until the next valley. Each period, the block outputs:

- a start pulse;
- the fully-on module count;
- the PWM bit;
- the synthesized arm level (fully-on count plus PWM bit), for checking;
- the carrier sample, registered and aligned with the other outputs.

Choosing which physical submodule takes which role is left to logic outside this block.

Top module: `arm_level_pwm`

## Requirements
- R1: While reset is held, period_start_o, full_on_o, pwm_o, level_o and carrier_o are all zero.
- R2: For a reference r below N_MOD·2^FRAC_W, full_on_o equals floor(r / 2^FRAC_W) and the duty d equals r mod 2^FRAC_W (the low FRAC_W bits). full_on_o never exceeds N_MOD−1.
- R3: A reference of N_MOD·2^FRAC_W or more saturates. full_on_o is N_MOD−1 and pwm_o stays 1 for the whole period, so the level is N_MOD throughout.
- R4: With effective half-period H (half_per_i, where 0 is read as 1), one carrier period lasts 2H cycles. The aligned carrier samples are 0,1,…,H,H−1,…,1. period_start_o is 1 exactly on the sample with value 0. The first period starts on the first clock after reset is released.
- R5: level_o equals full_on_o + pwm_o in every cycle, and is never above N_MOD.
- R6: The reference and half_per_i are sampled only at the valley. Changing either during a period has no effect on full_on_o, pwm_o or the carrier until the next period.
- R7: In each cycle, pwm_o is 1 exactly when d·H > c·2^FRAC_W, where c is the aligned carrier sample, or when d is the saturated value 2^FRAC_W. A duty of zero keeps pwm_o at 0.
- R8: Over one period with 0 < d < 2^FRAC_W, pwm_o is high for 1 + 2·#{c in 1..H−1 : c·2^FRAC_W < d·H} cycles. It is high for 0 cycles when d = 0 and for 2H cycles when saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_i | input | $clog2(N_MOD+1)+FRAC_W | Unsigned arm reference, FRAC_W fractional bits, unit one capacitor voltage |
| half_per_i | input | CAR_W | Carrier half-period in clocks; 0 is read as 1 |
| period_start_o | output | 1 | One-cycle pulse on the first sample of each carrier period |
| full_on_o | output | $clog2(N_MOD+1) | Count of fully inserted modules for this period |
| pwm_o | output | 1 | Switching bit of the single PWM module |
| level_o | output | $clog2(N_MOD+1) | Synthesized arm level in capacitor-voltage units |
| carrier_o | output | CAR_W | Carrier sample aligned with the outputs |

## Verification
The assertions assume that reset is applied before operation and that reference and half-period values arrive as plain unsigned numbers. Under those conditions, the carrier bound, the restart at the valley and the output hold across a period follow from the design alone. The bench changes its inputs only on falling edges, so the value captured at each valley is well defined. It deliberately disturbs both inputs halfway through a period to show that nothing moves before the next valley. Every reference code, including the saturated range, is swept at several half-periods, one of them zero.

// File: rtl/alp_pkg.sv
package alp_pkg;

  // Whole part of a reference: count of fully inserted modules, clamped.
  function automatic int unsigned level_whole(longint unsigned rv,
                                              int unsigned fw,
                                              int unsigned n);
    longint unsigned w;
    w = rv >> fw;
    if (w >= longint'(n)) return n - 1;
    return int'(w);
  endfunction

  // Fractional duty of a reference; saturated value is 2^fw.
  function automatic longint unsigned level_frac(longint unsigned rv,
                                                 int unsigned fw,
                                                 int unsigned n);
    longint unsigned w;
    longint unsigned one;
    one = 64'd1 << fw;
    w   = rv >> fw;
    if (w >= longint'(n)) return one;
    return rv & (one - 64'd1);
  endfunction

  // Carrier comparison scaled so the triangle spans 0..1 over 0..h.
  function automatic logic duty_above(longint unsigned d,
                                      longint unsigned c,
                                      longint unsigned h,
                                      int unsigned fw);
    if (d >= (64'd1 << fw)) return 1'b1;
    return (d * h) > (c << fw);
  endfunction

endpackage

// File: rtl/alp_carrier.sv
module alp_carrier #(
  parameter int CAR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CAR_W-1:0] half_per_i,
  output logic             valley_o,
  output logic [CAR_W-1:0] car_o,
  output logic [CAR_W-1:0] span_o
);
  localparam logic [CAR_W-1:0] ONE = CAR_W'(1);

  logic [CAR_W-1:0] car_q;
  logic [CAR_W-1:0] span_q;
  logic             up_q;
  logic [CAR_W-1:0] span_new;
  logic             at_valley;
  logic             at_peak;

  assign span_new  = (half_per_i == '0) ? ONE : half_per_i;
  assign at_valley = (car_q == '0);
  assign at_peak   = up_q && (car_q >= span_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      car_q  <= '0;
      span_q <= ONE;
      up_q   <= 1'b1;
    end else if (at_valley) begin
      car_q  <= ONE;
      span_q <= span_new;
      up_q   <= 1'b1;
    end else if (at_peak) begin
      car_q <= car_q - ONE;
      up_q  <= 1'b0;
    end else if (up_q) begin
      car_q <= car_q + ONE;
    end else begin
      car_q <= car_q - ONE;
    end
  end

  assign valley_o = at_valley;
  assign car_o    = car_q;
  assign span_o   = at_valley ? span_new : span_q;

  AST_CARRIER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    car_q <= span_q); // R4
  AST_VALLEY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    at_valley |=> (car_q == ONE)); // R4
  AST_PEAK_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (at_peak && !at_valley) |=> (!up_q && car_q == $past(car_q) - ONE)); // R4

endmodule

// File: rtl/alp_split.sv
module alp_split #(
  parameter int N_MOD  = 8,
  parameter int FRAC_W = 8,
  parameter int LVL_W  = 4,
  parameter int REF_W  = 12
) (
  input  logic [REF_W-1:0]  ref_i,
  output logic [LVL_W-1:0]  whole_o,
  output logic [FRAC_W:0]   frac_o
);
  always_comb begin
    whole_o = LVL_W'(alp_pkg::level_whole(64'(ref_i), FRAC_W, N_MOD));
    frac_o  = (FRAC_W+1)'(alp_pkg::level_frac(64'(ref_i), FRAC_W, N_MOD));
  end

  always_comb begin
    AST_SPLIT_RANGE: assert (int'(whole_o) < N_MOD); // R2
  end

endmodule

// File: rtl/alp_slicer.sv
module alp_slicer #(
  parameter int N_MOD  = 8,
  parameter int FRAC_W = 8,
  parameter int LVL_W  = 4,
  parameter int CAR_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valley_i,
  input  logic [LVL_W-1:0] whole_i,
  input  logic [FRAC_W:0]  frac_i,
  input  logic [CAR_W-1:0] car_i,
  input  logic [CAR_W-1:0] span_i,
  output logic             period_start_o,
  output logic [LVL_W-1:0] full_on_o,
  output logic             pwm_o,
  output logic [LVL_W-1:0] level_o,
  output logic [CAR_W-1:0] carrier_o
);
  localparam logic [FRAC_W:0] DUTY_FULL = {1'b1, {FRAC_W{1'b0}}};

  logic [LVL_W-1:0] whole_q;
  logic [FRAC_W:0]  frac_q;
  logic [LVL_W-1:0] whole_eff;
  logic [FRAC_W:0]  frac_eff;
  logic             pwm_next;

  assign whole_eff = valley_i ? whole_i : whole_q;
  assign frac_eff  = valley_i ? frac_i  : frac_q;
  assign pwm_next  = alp_pkg::duty_above(64'(frac_eff), 64'(car_i),
                                         64'(span_i), FRAC_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      whole_q        <= '0;
      frac_q         <= '0;
      period_start_o <= 1'b0;
      full_on_o      <= '0;
      pwm_o          <= 1'b0;
      level_o        <= '0;
      carrier_o      <= '0;
    end else begin
      if (valley_i) begin
        whole_q <= whole_i;
        frac_q  <= frac_i;
      end
      period_start_o <= valley_i;
      full_on_o      <= whole_eff;
      pwm_o          <= pwm_next;
      level_o        <= whole_eff + LVL_W'(pwm_next);
      carrier_o      <= car_i;
    end
  end

  AST_FULL_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start_o |-> $stable(full_on_o)); // R6
  AST_FULL_ON_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(full_on_o) < N_MOD); // R2
  AST_LEVEL_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level_o) <= N_MOD); // R5
  AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    period_start_o |=> !period_start_o); // R4
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (valley_i && frac_i == '0) |=> !pwm_o); // R7
  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (valley_i && frac_i == DUTY_FULL) |=> pwm_o); // R3

endmodule

// File: rtl/arm_level_pwm.sv
module arm_level_pwm #(
  parameter int N_MOD  = 8,
  parameter int FRAC_W = 8,
  parameter int CAR_W  = 10
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [$clog2(N_MOD+1)+FRAC_W-1:0]   ref_i,
  input  logic [CAR_W-1:0]                    half_per_i,
  output logic                                period_start_o,
  output logic [$clog2(N_MOD+1)-1:0]          full_on_o,
  output logic                                pwm_o,
  output logic [$clog2(N_MOD+1)-1:0]          level_o,
  output logic [CAR_W-1:0]                    carrier_o
);
  localparam int LVL_W = $clog2(N_MOD+1);
  localparam int REF_W = LVL_W + FRAC_W;

  logic             valley;
  logic [CAR_W-1:0] car;
  logic [CAR_W-1:0] span;
  logic [LVL_W-1:0] whole;
  logic [FRAC_W:0]  frac;

  alp_carrier #(.CAR_W(CAR_W)) u_carrier (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_per_i (half_per_i),
    .valley_o   (valley),
    .car_o      (car),
    .span_o     (span)
  );

  alp_split #(.N_MOD(N_MOD), .FRAC_W(FRAC_W), .LVL_W(LVL_W), .REF_W(REF_W)) u_split (
    .ref_i   (ref_i),
    .whole_o (whole),
    .frac_o  (frac)
  );

  alp_slicer #(.N_MOD(N_MOD), .FRAC_W(FRAC_W), .LVL_W(LVL_W), .CAR_W(CAR_W)) u_slicer (
    .clk            (clk),
    .rst_n          (rst_n),
    .valley_i       (valley),
    .whole_i        (whole),
    .frac_i         (frac),
    .car_i          (car),
    .span_i         (span),
    .period_start_o (period_start_o),
    .full_on_o      (full_on_o),
    .pwm_o          (pwm_o),
    .level_o        (level_o),
    .carrier_o      (carrier_o)
  );

  AST_FIRST_VALLEY: assert property (@(posedge clk)
    !rst_n |=> (car == '0)); // R1

endmodule

// File: tb/tb_arm_level_pwm.sv
`timescale 1ns/1ps
module tb_arm_level_pwm;
  localparam int NM = 4;
  localparam int FW = 3;
  localparam int CW = 5;
  localparam int LW = 3;
  localparam int RW = LW + FW;
  localparam int ONE = 1 << FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] ref_i = '0;
  logic [CW-1:0] half_per_i = '0;
  logic          period_start_o;
  logic [LW-1:0] full_on_o;
  logic          pwm_o;
  logic [LW-1:0] level_o;
  logic [CW-1:0] carrier_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  arm_level_pwm #(.N_MOD(NM), .FRAC_W(FW), .CAR_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .half_per_i(half_per_i),
    .period_start_o(period_start_o), .full_on_o(full_on_o), .pwm_o(pwm_o),
    .level_o(level_o), .carrier_o(carrier_o)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_period(input int rv, input int h);
    int  heff, ef, ed, on_cnt, exp_on, ec;
    bit  sat, ep;
    string fq;
    ref_i      = RW'(rv);
    half_per_i = CW'(h);
    @(negedge clk);
    while (!period_start_o) @(negedge clk);
    heff = (h == 0) ? 1 : h;
    sat  = (rv >= NM * ONE);
    ef   = sat ? NM - 1 : rv / ONE;
    ed   = sat ? ONE : rv % ONE;
    on_cnt = 0;
    for (int k = 0; k < 2 * heff; k++) begin
      if (k > 0) @(negedge clk);
      ec = (k <= heff) ? k : 2 * heff - k;
      chk("R4", "carrier sample", carrier_o, ec);
      chk("R4", "start pulse", period_start_o, (k == 0));
      fq = (k > heff) ? "R6" : (sat ? "R3" : "R2");
      chk(fq, "full_on", full_on_o, ef);
      ep = (ed == ONE) || (ed * heff > ec * ONE);
      chk(sat ? "R3" : "R7", "pwm", pwm_o, ep);
      chk("R5", "level", level_o, ef + ep);
      chk("R5", "level sum", level_o, full_on_o + pwm_o);
      on_cnt += pwm_o;
      if (k == heff) begin
        ref_i      = RW'(rv ^ 21);
        half_per_i = CW'(h + 3);
      end
    end
    if (ed == ONE) exp_on = 2 * heff;
    else if (ed == 0) exp_on = 0;
    else begin
      exp_on = 1;
      for (int c = 1; c < heff; c++) if (c * ONE < ed * heff) exp_on += 2;
    end
    chk("R8", "on count", on_cnt, exp_on);
    @(negedge clk);
    chk("R4", "period length", period_start_o, 1);
  endtask

  initial begin
    int hs[4];
    hs = '{0, 1, 3, 8};
    ref_i = 6'd37;
    half_per_i = 5'd4;
    repeat (3) begin
      @(negedge clk);
      chk("R1", "start in reset", period_start_o, 0);
      chk("R1", "full_on in reset", full_on_o, 0);
      chk("R1", "pwm in reset", pwm_o, 0);
      chk("R1", "level in reset", level_o, 0);
      chk("R1", "carrier in reset", carrier_o, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4", "first start after reset", period_start_o, 1);
    chk("R3", "first full_on", full_on_o, NM - 1);
    for (int i = 0; i < 4; i++)
      for (int r = 0; r < (1 << RW); r++)
        run_period(r, hs[i]);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog: cycles=%0d expected<%0d", 150000, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule